// File: doc/BRIEF.md
# Write-Back Data Cache with Line Claim and Lock-Aware Flush

This block is a direct-mapped, write-back data cache of 32-byte lines that sits between a processor and a line-wide memory port. The processor side issues one request at a time: a word load, a word store, or one of four maintenance commands. Allocate claims a line for an address without reading memory. Invalidate-all drops every line that is not locked. Lock and unlock pin or release the line that holds an address. Each line carries a tag plus valid, dirty and lock bits. A store hit marks the line dirty. A dirty line is written back only when it must give way to another address.

Software can clean the cache by claiming a run of spare line addresses, because each claim pushes out the dirty line it replaces. It can then flush with invalidate-all, which leaves pinned lines in place. A load or store that misses on a pinned line bypasses the cache and makes a single-word memory access.

The memory side uses a request/acknowledge handshake. The request and its address are held until the acknowledge arrives, and one transfer completes per acknowledge.

Top module: `wb_dcache`

## Requirements
- R1: After reset, `cpu_busy`, `cpu_done` and `mem_req` are low and every line is invalid, so the first load of any address causes a line read.
- R2: A load (op 0) that hits returns the word selected by address bits [4:2] and makes no memory request.
- R3: A load or store (op 1) that misses on an invalid or clean line issues one full-line read (`mem_full`=1, `mem_we`=0) at the line-aligned address, then completes the access from the filled line. Word k of a line travels on bits [32k+31:32k].
- R4: A store hit updates one word and marks the line dirty. When that line is later displaced, it is written back as a full line at its own line address before the new line is read.
- R5: Allocate (op 2) never issues a memory read. A dirty victim is written back first. Afterwards the line is valid, clean and tagged with the new address, and its data is left unchanged.
- R6: Invalidate-all (op 3) makes every unlocked line invalid within one command and issues no write-back. Dirty data in those lines is discarded.
- R7: Lock (op 4) on a hit pins the line. Invalidate-all leaves a pinned line valid with its data intact. Only after unlock (op 5) on a hit can invalidate-all remove that line.
- R8: A load or store that misses on a line that is both pinned and valid makes one single-word access (`mem_full`=0) at the request address and does not replace the pinned line.
- R9: Lock or unlock on an address that misses changes nothing and completes without memory traffic.
- R10: `cpu_done` is a one-cycle pulse in the cycle after a command finishes, and `cpu_busy` is high from acceptance until then. While waiting for an acknowledge, `mem_req`, `mem_addr` and `mem_we` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Request strobe, taken when not busy |
| cpu_op | input | 3 | 0 load, 1 store, 2 allocate, 3 invalidate-all, 4 lock, 5 unlock |
| cpu_addr | input | AW | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_busy | output | 1 | A request is in progress |
| cpu_done | output | 1 | Completion pulse |
| cpu_rdata | output | 32 | Load result, valid with `cpu_done` |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_full | output | 1 | 1 whole line, 0 single word in bits [31:0] |
| mem_addr | output | AW | Line address, or byte address for a word transfer |
| mem_wdata | output | 256 | Write data |
| mem_rdata | input | 256 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Transfer complete |

## Verification
The bench targets a dirty victim that must leave before its replacement arrives. A design that fills first would lose the stored word, or would write back the wrong line address. Allocate is checked for any read traffic and for whether the line is usable afterwards. A design that fetches the line would show an extra read, and one that forgets to set the tag would miss on the next load. A pinned, dirty line is taken through invalidate-all and through misses that map onto it. A design that ignores the lock would lose the line or evict it, and one that mishandles the bypass would fetch a full line. Lock on a missing address is also exercised, which exposes a design that drops the tag compare.

// File: rtl/wb_dcache.sv
module wb_dcache #(
  parameter int LINES = 1024,
  parameter int AW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic [2:0]    cpu_op,
  input  logic [AW-1:0] cpu_addr,
  input  logic [31:0]   cpu_wdata,
  output logic          cpu_busy,
  output logic          cpu_done,
  output logic [31:0]   cpu_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_full,
  output logic [AW-1:0] mem_addr,
  output logic [255:0]  mem_wdata,
  input  logic [255:0]  mem_rdata,
  input  logic          mem_ack
);
  localparam int OFFW = 5;
  localparam int IDXW = $clog2(LINES);
  localparam int TAGW = AW - OFFW - IDXW;
  localparam int LW   = 256;

  localparam logic [2:0] OP_LD = 3'd0, OP_ST = 3'd1, OP_AL = 3'd2,
                         OP_INV = 3'd3, OP_LK = 3'd4, OP_UL = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_EXEC, S_WB, S_FILL, S_BYP} st_t;

  st_t st_q, nxt;
  logic [2:0]    op_q;
  logic [AW-1:0] addr_q;
  logic [31:0]   wdata_q, rdata_q;
  logic          done_q;

  logic [LW-1:0]   data_q [LINES];
  logic [TAGW-1:0] tag_q  [LINES];
  logic [LINES-1:0] valid_q, dirty_q, lock_q;

  logic [IDXW-1:0] idx;
  logic [TAGW-1:0] tg;
  logic [2:0]      woff;
  logic [LW-1:0]   line;
  logic [31:0]     word;
  logic hit, vlock, vdirty, is_acc;
  logic fin, wr_word, claim;

  assign idx    = addr_q[OFFW +: IDXW];
  assign tg     = addr_q[AW-1 -: TAGW];
  assign woff   = addr_q[4:2];
  assign line   = data_q[idx];
  assign word   = line[{woff, 5'b0} +: 32];
  assign hit    = valid_q[idx] && (tag_q[idx] == tg);
  assign vlock  = valid_q[idx] && lock_q[idx];
  assign vdirty = valid_q[idx] && dirty_q[idx];
  assign is_acc = (op_q == OP_LD) || (op_q == OP_ST);

  assign cpu_busy  = (st_q != S_IDLE);
  assign cpu_done  = done_q;
  assign cpu_rdata = rdata_q;
  assign mem_req   = (st_q == S_WB) || (st_q == S_FILL) || (st_q == S_BYP);
  assign mem_we    = (st_q == S_WB) || ((st_q == S_BYP) && (op_q == OP_ST));
  assign mem_full  = (st_q != S_BYP);
  assign mem_addr  = (st_q == S_WB)   ? {tag_q[idx], idx, 5'b0} :
                     (st_q == S_FILL) ? {tg, idx, 5'b0} : addr_q;
  assign mem_wdata = (st_q == S_BYP) ? {{(LW-32){1'b0}}, wdata_q} : line;

  always_comb begin
    nxt     = st_q;
    fin     = 1'b0;
    wr_word = 1'b0;
    claim   = 1'b0;
    case (st_q)
      S_IDLE: if (cpu_req) nxt = S_EXEC;
      S_EXEC: begin
        if (is_acc) begin
          if (hit) begin
            fin     = 1'b1;
            wr_word = (op_q == OP_ST);
          end else if (vlock)  nxt = S_BYP;
          else if (vdirty)     nxt = S_WB;
          else                 nxt = S_FILL;
        end else if (op_q == OP_AL && !hit && !vlock) begin
          if (vdirty) nxt = S_WB;
          else begin
            claim = 1'b1;
            fin   = 1'b1;
          end
        end else begin
          fin = 1'b1;
        end
        if (fin) nxt = S_IDLE;
      end
      S_WB, S_FILL: if (mem_ack) nxt = S_EXEC;
      S_BYP: if (mem_ack) begin
        nxt = S_IDLE;
        fin = 1'b1;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      done_q  <= 1'b0;
      op_q    <= OP_LD;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      valid_q <= '0;
      dirty_q <= '0;
      lock_q  <= '0;
    end else begin
      st_q   <= nxt;
      done_q <= fin;
      if (st_q == S_IDLE && cpu_req) begin
        op_q    <= cpu_op;
        addr_q  <= cpu_addr;
        wdata_q <= cpu_wdata;
      end
      if (st_q == S_EXEC && op_q == OP_LD && hit) rdata_q <= word;
      if (st_q == S_BYP && mem_ack && op_q == OP_LD) rdata_q <= mem_rdata[31:0];
      if (wr_word) dirty_q[idx] <= 1'b1;
      if (claim || (st_q == S_FILL && mem_ack)) begin
        valid_q[idx] <= 1'b1;
        dirty_q[idx] <= 1'b0;
        lock_q[idx]  <= 1'b0;
      end
      if (st_q == S_WB && mem_ack) dirty_q[idx] <= 1'b0;
      if (st_q == S_EXEC) begin
        case (op_q)
          OP_INV: begin
            valid_q <= valid_q & lock_q;
            dirty_q <= dirty_q & lock_q;
          end
          OP_LK: if (hit) lock_q[idx] <= 1'b1;
          OP_UL: if (hit) lock_q[idx] <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_word) data_q[idx][{woff, 5'b0} +: 32] <= wdata_q;
    if (st_q == S_FILL && mem_ack) begin
      data_q[idx] <= mem_rdata;
      tag_q[idx]  <= tg;
    end
    if (claim) tag_q[idx] <= tg;
  end

endmodule

// File: rtl/wb_dcache_chk.sv
module wb_dcache_chk #(
  parameter int LINES = 1024,
  parameter int AW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_done,
  input logic             cpu_busy,
  input logic             mem_req,
  input logic             mem_ack,
  input logic             mem_we,
  input logic             mem_full,
  input logic [AW-1:0]    mem_addr,
  input logic [2:0]       op_q,
  input logic [LINES-1:0] valid_q,
  input logic [LINES-1:0] dirty_q,
  input logic [LINES-1:0] lock_q
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done); // R10
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_busy |-> !mem_req); // R10
  AST_ALLOC_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |-> op_q != 3'd2); // R5
  AST_WORD_ONLY_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_full |-> (op_q == 3'd0 || op_q == 3'd1)); // R8
  AST_LOCK_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q & ~valid_q) == '0); // R7
  AST_DIRTY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (dirty_q & ~valid_q) == '0); // R6
endmodule

bind wb_dcache wb_dcache_chk #(.LINES(LINES), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_done(cpu_done), .cpu_busy(cpu_busy),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we), .mem_full(mem_full),
  .mem_addr(mem_addr), .op_q(op_q), .valid_q(valid_q), .dirty_q(dirty_q),
  .lock_q(lock_q)
);

// File: tb/wb_dcache_tb.sv
module wb_dcache_tb;
  localparam int LINES = 8;
  localparam int AW    = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 1'b0;
  logic [2:0] cpu_op = '0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic cpu_busy, cpu_done;
  logic [31:0] cpu_rdata;
  logic mem_req, mem_we, mem_full;
  logic [31:0] mem_addr;
  logic [255:0] mem_wdata;
  logic [255:0] mem_rdata = '0;
  logic mem_ack = 1'b0;

  always #2 clk = ~clk;

  wb_dcache #(.LINES(LINES), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_op(cpu_op),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_busy(cpu_busy),
    .cpu_done(cpu_done), .cpu_rdata(cpu_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_full(mem_full), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  int checks = 0, fails = 0, cyc = 0;
  int rd_cnt = 0, wb_cnt = 0, dly = 0;
  logic [31:0] last_wba = '0;
  logic [255:0] last_wline = '0;
  logic last_full = 1'b0;

  function automatic logic [255:0] line_pat(input logic [31:0] a);
    logic [255:0] l;
    for (int w = 0; w < 8; w++) l[32*w +: 32] = ({a[31:5], 5'b0} + 32'(4*w)) ^ 32'h5A5A0000;
    return l;
  endfunction

  always @(negedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      if (dly >= 1) begin
        dly <= 0;
        mem_ack <= 1'b1;
        if (mem_we) begin
          wb_cnt <= wb_cnt + 1; last_wba <= mem_addr; last_wline <= mem_wdata;
        end else begin
          rd_cnt <= rd_cnt + 1; last_full <= mem_full;
        end
        mem_rdata <= mem_full ? line_pat(mem_addr) : {224'b0, mem_addr ^ 32'h5A5A0000};
      end else dly <= dly + 1;
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: act %0d cycles exp <= 100000", cyc);
      summary();
    end
  end

  task automatic ck(input int rq, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: act %h exp %h", rq, what, act, exp);
    end
  endtask

  logic busy_seen;
  task automatic do_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] wd,
                       output logic [31:0] rd, output int nrd, output int nwb);
    int r0, w0, n;
    r0 = rd_cnt; w0 = wb_cnt; n = 0;
    cpu_op = op; cpu_addr = a; cpu_wdata = wd; cpu_req = 1'b1;
    @(negedge clk);
    cpu_req = 1'b0;
    busy_seen = cpu_busy;
    while (!cpu_done && n < 500) begin
      @(negedge clk);
      n++;
    end
    if (n >= 500) begin
      fails++;
      $display("FAIL R10 timeout: act no done exp done");
    end
    rd = cpu_rdata; nrd = rd_cnt - r0; nwb = wb_cnt - w0;
  endtask

  typedef struct packed {
    logic [3:0]  rq;
    logic [2:0]  op;
    logic [31:0] addr;
    logic [31:0] wd;
    logic        chk;
    logic [31:0] erd;
    logic [3:0]  nrd;
    logic [3:0]  nwb;
    logic [31:0] wba;
    logic [1:0]  full;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t TBL [NV] = '{
    '{4'd3, 3'd0, 32'h100, 32'h0,        1'b1, 32'h5A5A0100, 4'd1, 4'd0, 32'h0,   2'd3}, // R3 cold miss
    '{4'd2, 3'd0, 32'h104, 32'h0,        1'b1, 32'h5A5A0104, 4'd0, 4'd0, 32'h0,   2'd0}, // R2 hit
    '{4'd4, 3'd1, 32'h108, 32'hDEADBEEF, 1'b0, 32'h0,        4'd0, 4'd0, 32'h0,   2'd0}, // R4 store hit
    '{4'd4, 3'd0, 32'h108, 32'h0,        1'b1, 32'hDEADBEEF, 4'd0, 4'd0, 32'h0,   2'd0}, // R4
    '{4'd4, 3'd0, 32'h200, 32'h0,        1'b1, 32'h5A5A0200, 4'd1, 4'd1, 32'h100, 2'd3}, // R4 dirty victim
    '{4'd3, 3'd1, 32'h320, 32'h11112222, 1'b0, 32'h0,        4'd1, 4'd0, 32'h0,   2'd3}, // R3 store miss
    '{4'd2, 3'd0, 32'h320, 32'h0,        1'b1, 32'h11112222, 4'd0, 4'd0, 32'h0,   2'd0}, // R2
    '{4'd5, 3'd2, 32'h520, 32'h0,        1'b0, 32'h0,        4'd0, 4'd1, 32'h320, 2'd0}, // R5 alloc dirty victim
    '{4'd5, 3'd0, 32'h520, 32'h0,        1'b0, 32'h0,        4'd0, 4'd0, 32'h0,   2'd0}, // R5 now hits
    '{4'd7, 3'd4, 32'h200, 32'h0,        1'b0, 32'h0,        4'd0, 4'd0, 32'h0,   2'd0}, // R7 lock
    '{4'd7, 3'd1, 32'h204, 32'hCAFEF00D, 1'b0, 32'h0,        4'd0, 4'd0, 32'h0,   2'd0}, // R7
    '{4'd6, 3'd3, 32'h0,   32'h0,        1'b0, 32'h0,        4'd0, 4'd0, 32'h0,   2'd0}, // R6 no writeback
    '{4'd7, 3'd0, 32'h204, 32'h0,        1'b1, 32'hCAFEF00D, 4'd0, 4'd0, 32'h0,   2'd0}, // R7 survived
    '{4'd6, 3'd0, 32'h520, 32'h0,        1'b1, 32'h5A5A0520, 4'd1, 4'd0, 32'h0,   2'd3}, // R6 dropped
    '{4'd8, 3'd0, 32'h404, 32'h0,        1'b1, 32'h5A5A0404, 4'd1, 4'd0, 32'h0,   2'd2}, // R8 bypass load
    '{4'd8, 3'd0, 32'h204, 32'h0,        1'b1, 32'hCAFEF00D, 4'd0, 4'd0, 32'h0,   2'd0}, // R8 line kept
    '{4'd8, 3'd1, 32'h408, 32'h77,       1'b0, 32'h0,        4'd0, 4'd1, 32'h408, 2'd0}, // R8 bypass store
    '{4'd9, 3'd4, 32'h700, 32'h0,        1'b0, 32'h0,        4'd0, 4'd0, 32'h0,   2'd0}, // R9
    '{4'd7, 3'd5, 32'h200, 32'h0,        1'b0, 32'h0,        4'd0, 4'd0, 32'h0,   2'd0}, // R7 unlock
    '{4'd7, 3'd3, 32'h0,   32'h0,        1'b0, 32'h0,        4'd0, 4'd0, 32'h0,   2'd0}, // R7
    '{4'd7, 3'd0, 32'h204, 32'h0,        1'b1, 32'h5A5A0204, 4'd1, 4'd0, 32'h0,   2'd3}  // R7 gone
  };

  initial begin
    logic [31:0] rd;
    int nrd, nwb;
    repeat (4) @(negedge clk);
    ck(1, {29'b0, cpu_busy, cpu_done, mem_req}, 32'h0, "idle outputs in reset"); // R1
    rst_n = 1'b1;
    @(negedge clk);
    ck(1, {29'b0, cpu_busy, cpu_done, mem_req}, 32'h0, "idle outputs after reset"); // R1

    for (int i = 0; i < NV; i++) begin
      do_op(TBL[i].op, TBL[i].addr, TBL[i].wd, rd, nrd, nwb);
      if (TBL[i].chk) ck(TBL[i].rq, rd, TBL[i].erd, "rdata");
      ck(TBL[i].rq, nrd, 32'(TBL[i].nrd), "reads");
      ck(TBL[i].rq, nwb, 32'(TBL[i].nwb), "writes");
      if (TBL[i].wba != 0) ck(TBL[i].rq, last_wba, TBL[i].wba, "write address");
      if (TBL[i].full[1]) ck(TBL[i].rq, {31'b0, last_full}, {31'b0, TBL[i].full[0]}, "full flag");
    end

    // R10 busy and done pulse
    do_op(3'd0, 32'h204, 32'h0, rd, nrd, nwb);
    ck(10, {31'b0, busy_seen}, 32'h1, "busy after accept");
    @(negedge clk);
    ck(10, {31'b0, cpu_done}, 32'h0, "done width");

    // R4 written-back line contents
    do_op(3'd1, 32'h0E8, 32'h13572468, rd, nrd, nwb);
    ck(3, nrd, 1, "store miss fill");
    do_op(3'd0, 32'h1E0, 32'h0, rd, nrd, nwb);
    ck(4, nwb, 1, "evict writes");
    ck(4, last_wba, 32'h0E0, "evict address");
    ck(4, last_wline[95:64], 32'h13572468, "evict stored word");
    ck(4, last_wline[31:0], 32'h5A5A00E0, "evict filled word");
    ck(3, rd, 32'h5A5A01E0, "fill after evict");

    // R5 allocate on a clean miss
    do_op(3'd2, 32'h2C0, 32'h0, rd, nrd, nwb);
    ck(5, nrd + nwb, 0, "clean claim traffic");
    do_op(3'd0, 32'h2C0, 32'h0, rd, nrd, nwb);
    ck(5, nrd, 0, "claimed line hits");

    // R9 lock on a miss pins nothing
    do_op(3'd4, 32'h3C0, 32'h0, rd, nrd, nwb);
    ck(9, nrd + nwb, 0, "lock miss traffic");
    do_op(3'd3, 32'h0, 32'h0, rd, nrd, nwb);
    do_op(3'd0, 32'h2C0, 32'h0, rd, nrd, nwb);
    ck(9, nrd, 1, "line not pinned");

    summary();
  end
endmodule